// File: doc/BRIEF.md
# Instruction Queue Shadow Tracker

This block keeps a copy of a processor's instruction prefetch queue, built from outside the processor. It watches the three bus-status lines to find out which bus cycles fetch code. Each byte read in such a cycle is copied from the data bus into a small shadow FIFO. The processor never pushes to or pops from this FIFO directly.

Every clock, the block decodes the processor's two queue-status lines. These lines report the queue operation of the previous clock, and the block applies that code in the cycle it arrives. A code can take one byte from the shadow queue or empty the whole queue. Each byte taken appears on the output one clock later, tagged as either the first byte of an opcode or a later byte of the same instruction. Two sticky flags record when a fetched byte did not fit and when a byte was requested from an empty queue.

Top module: `qshadow_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, the queue is emptied and `out_valid`, `overflow` and `underflow` are cleared. After reset, a pop request finds the queue empty.
- R2: A byte on `bus_data` is captured on a clock with `bus_strobe` high only if the current bus cycle is a code fetch (`bus_status` = 3'b100). Bytes read in memory-read (3'b101) or other cycles are not captured.
- R3: Queue status 2'b00 means no operation. On the next clock `out_valid` is low, and the shadow contents are unchanged.
- R4: Queue status 2'b01 takes the oldest byte. On the next clock it appears on `out_byte` with `out_valid` = 1 and `out_first` = 1.
- R5: Queue status 2'b11 takes the oldest byte. On the next clock it appears with `out_valid` = 1 and `out_first` = 0.
- R6: Queue status 2'b10 discards every shadow entry and produces no output byte.
- R7: Bytes leave the queue in the order they were captured.
- R8: The queue holds DEPTH bytes (default 6). A capture while the queue is full and nothing is taken in the same clock drops the byte and sets the sticky `overflow` flag.
- R9: A take request (2'b01 or 2'b11) while the queue is empty sets the sticky `underflow` flag, and `out_valid` stays low on the next clock.
- R10: When a flush and a capture happen in the same clock, the flush is applied first and the new byte is kept as the only entry.
- R11: When the queue is full, a take and a capture in the same clock both succeed, and `overflow` is not set.
- R12: `bus_status` is 3'b111 (passive) while the data byte is read. The cycle kind is the one latched from the last non-passive status, and a strobe with a non-passive status uses that status directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_status | input | 3 | Processor bus-cycle status code |
| bus_strobe | input | 1 | Data-bus byte valid for the current read |
| bus_data | input | 8 | Data-bus byte |
| queue_status | input | 2 | Processor queue-status code |
| out_valid | output | 1 | A byte was taken from the queue last clock |
| out_byte | output | 8 | The taken byte |
| out_first | output | 1 | 1: first opcode byte, 0: later byte |
| overflow | output | 1 | Sticky: a fetched byte was dropped |
| underflow | output | 1 | Sticky: a take was requested on an empty queue |

## Verification
The hardest case to reach from the ports is a full queue that sees a take and a capture in the same clock. The queue must first be filled to exactly DEPTH bytes with no takes. Then a code-fetch strobe and a take code must land on the same edge. The directed part of the bench does this, and then pushes one more byte to trigger an overflow. It then drains the queue to show that the bytes leave in order and that the dropped byte is really gone. The vector table covers a second hard case. A strobe arrives while the status is passive after a memory read, and the latched cycle kind must reject that byte.

// File: rtl/qshadow_pkg.sv
package qshadow_pkg;

    localparam int BYTE_W = 8;

    // Queue-status codes seen from the processor (one clock late)
    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_LATER = 2'b11
    } qs_code_e;

    // Bus-status codes the snooper cares about
    localparam logic [2:0] BUS_CODE_FETCH = 3'b100;
    localparam logic [2:0] BUS_PASSIVE    = 3'b111;

    // Registered output state of the tracker
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              first;
        logic              ovf;
        logic              unf;
    } out_state_t;

endpackage

// File: rtl/qshadow_snoop.sv
module qshadow_snoop
    import qshadow_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_status,
    input  logic       bus_strobe,
    output logic       push
);

    // Latched "current cycle is a code fetch"
    logic code_d, code_q;
    logic active;

    always_comb begin
        active = (bus_status != BUS_PASSIVE);
        code_d = code_q;
        if (active) begin
            code_d = (bus_status == BUS_CODE_FETCH);
        end
        push = bus_strobe && (active ? (bus_status == BUS_CODE_FETCH) : code_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= 1'b0;
        end else begin
            code_q <= code_d;
        end
    end

endmodule

// File: rtl/qshadow_decode.sv
module qshadow_decode
    import qshadow_pkg::*;
(
    input  logic [1:0] queue_status,
    output logic       take,
    output logic       take_first,
    output logic       flush
);

    always_comb begin
        take       = 1'b0;
        take_first = 1'b0;
        flush      = 1'b0;
        unique case (qs_code_e'(queue_status))
            QS_IDLE:  ;
            QS_FIRST: begin
                take       = 1'b1;
                take_first = 1'b1;
            end
            QS_FLUSH: flush = 1'b1;
            QS_LATER: take  = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/qshadow_fifo.sv
module qshadow_fifo #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              push,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              pop,
    input  logic                              flush,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              pop_ok,
    output logic                              pop_empty,
    output logic                              push_drop,
    output logic [$clog2(DEPTH+1)-1:0]        level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    logic push_ok;

    always_comb begin
        s_d       = s_q;
        pop_empty = pop && !flush && (s_q.cnt == '0);
        pop_ok    = pop && !flush && (s_q.cnt != '0);
        push_ok   = push && (flush || (s_q.cnt != FULL) || pop_ok);
        push_drop = push && !push_ok;

        if (flush) begin
            // flush first, then keep a same-cycle byte
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
            if (push_ok) begin
                s_d.mem[0] = wr_data;
                s_d.wr     = bump('0);
                s_d.cnt    = CNT_W'(1);
            end
        end else begin
            if (pop_ok) begin
                s_d.rd = bump(s_q.rd);
            end
            if (push_ok) begin
                s_d.mem[s_q.wr] = wr_data;
                s_d.wr          = bump(s_q.wr);
            end
            case ({push_ok, pop_ok})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.mem <= '0;
            s_q.wr  <= '0;
            s_q.rd  <= '0;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.mem[s_q.rd];
    assign level   = s_q.cnt;

endmodule

// File: rtl/qshadow_tracker.sv
module qshadow_tracker
    import qshadow_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_status,
    input  logic              bus_strobe,
    input  logic [BYTE_W-1:0] bus_data,
    input  logic [1:0]        queue_status,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_first,
    output logic              overflow,
    output logic              underflow
);

    localparam int CNT_W = $clog2(DEPTH+1);

    logic              snoop_push;
    logic              dec_take;
    logic              dec_first;
    logic              dec_flush;
    logic [BYTE_W-1:0] head_byte;
    logic              take_ok;
    logic              take_empty;
    logic              push_drop;
    logic [CNT_W-1:0]  fill_level;

    qshadow_snoop u_snoop (
        .clk        (clk),
        .rst        (rst),
        .bus_status (bus_status),
        .bus_strobe (bus_strobe),
        .push       (snoop_push)
    );

    qshadow_decode u_decode (
        .queue_status (queue_status),
        .take         (dec_take),
        .take_first   (dec_first),
        .flush        (dec_flush)
    );

    qshadow_fifo #(
        .DEPTH  (DEPTH),
        .DATA_W (BYTE_W)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (snoop_push),
        .wr_data   (bus_data),
        .pop       (dec_take),
        .flush     (dec_flush),
        .rd_data   (head_byte),
        .pop_ok    (take_ok),
        .pop_empty (take_empty),
        .push_drop (push_drop),
        .level     (fill_level)
    );

    out_state_t o_d, o_q;

    always_comb begin
        o_d       = o_q;
        o_d.valid = take_ok;
        o_d.first = take_ok && dec_first;
        o_d.data  = take_ok ? head_byte : o_q.data;
        o_d.ovf   = o_q.ovf | push_drop;
        o_d.unf   = o_q.unf | take_empty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.valid;
    assign out_byte  = o_q.data;
    assign out_first = o_q.first;
    assign overflow  = o_q.ovf;
    assign underflow = o_q.unf;

endmodule

// File: rtl/qshadow_checker.sv
module qshadow_checker #(
    parameter int DEPTH = 6
) (
    input logic                       clk,
    input logic                       rst,
    input logic [1:0]                 queue_status,
    input logic                       push,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       out_valid,
    input logic                       out_first,
    input logic                       overflow,
    input logic                       underflow
);

    localparam int CNT_W = $clog2(DEPTH+1);

    a_r3_idle_silent: assert property (@(posedge clk) disable iff (rst)
        queue_status == 2'b00 |=> !out_valid);

    a_r4_first_tag: assert property (@(posedge clk) disable iff (rst)
        (queue_status == 2'b01 && level != '0) |=> (out_valid && out_first));

    a_r5_later_tag: assert property (@(posedge clk) disable iff (rst)
        (queue_status == 2'b11 && level != '0) |=> (out_valid && !out_first));

    a_r6_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (queue_status == 2'b10 && !push) |=> (level == '0 && !out_valid));

    a_r10_flush_keeps_new: assert property (@(posedge clk) disable iff (rst)
        (queue_status == 2'b10 && push) |=> level == CNT_W'(1));

    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r8_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));

    a_r9_empty_take: assert property (@(posedge clk) disable iff (rst)
        (queue_status[0] && level == '0) |=> (underflow && !out_valid));

    a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    a_r11_full_swap: assert property (@(posedge clk) disable iff (rst)
        (queue_status[0] && push && level == CNT_W'(DEPTH) && !overflow) |=> !overflow);

endmodule

bind qshadow_tracker qshadow_checker #(.DEPTH(DEPTH)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .queue_status (queue_status),
    .push         (snoop_push),
    .level        (fill_level),
    .out_valid    (out_valid),
    .out_first    (out_first),
    .overflow     (overflow),
    .underflow    (underflow)
);

// File: tb/test_qshadow_tracker.sv
module test_qshadow_tracker;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    localparam int VW = 26;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_status = 3'b111;
    logic       bus_strobe = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic [1:0] queue_status = 2'b00;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_first;
    logic       overflow;
    logic       underflow;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qshadow_tracker i_qshadow_tracker (
        .clk          (clk),
        .rst          (rst),
        .bus_status   (bus_status),
        .bus_strobe   (bus_strobe),
        .bus_data     (bus_data),
        .queue_status (queue_status),
        .out_valid    (out_valid),
        .out_byte     (out_byte),
        .out_first    (out_first),
        .overflow     (overflow),
        .underflow    (underflow)
    );

    // {status, strobe, data, qs, exp_valid, exp_first, exp_byte, exp_ovf, exp_unf}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {3'b100, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {3'b111, 1'b1, 8'hA1, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {3'b100, 1'b1, 8'hB2, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {3'b101, 1'b1, 8'hEE, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},
        {3'b111, 1'b1, 8'hEF, 2'b01, 1'b1, 1'b1, 8'hA1, 1'b0, 1'b0},
        {3'b111, 1'b0, 8'h00, 2'b11, 1'b1, 1'b0, 8'hB2, 1'b0, 1'b0},
        {3'b111, 1'b0, 8'h00, 2'b01, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
        {3'b100, 1'b1, 8'hC3, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
        {3'b100, 1'b1, 8'hD4, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
        {3'b111, 1'b0, 8'h00, 2'b10, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
        {3'b111, 1'b0, 8'h00, 2'b01, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
        {3'b100, 1'b1, 8'h55, 2'b10, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
        {3'b111, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
        {3'b111, 1'b0, 8'h00, 2'b11, 1'b1, 1'b0, 8'h55, 1'b0, 1'b1},
        {3'b111, 1'b0, 8'h00, 2'b11, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1}
    };

    localparam string TAGS [NVEC] = '{
        "R12 latch code fetch", "R12 passive strobe", "R2 code byte",
        "R2 memread ignored", "R4 first tag", "R5 later tag R7",
        "R9 empty take", "R2 capture", "R2 capture", "R6 flush",
        "R6 flushed empty", "R10 flush+push", "R3 idle keeps",
        "R10 kept byte", "R10 only one byte"
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive at negedge, one rising edge, sample at the next negedge
    task automatic step(input logic [2:0] st, input logic sb, input logic [7:0] d,
                        input logic [1:0] qs);
        bus_status   = st;
        bus_strobe   = sb;
        bus_data     = d;
        queue_status = qs;
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic v, input logic f,
                              input logic [7:0] b, input logic ov, input logic un);
        check({tag, " valid"}, {31'd0, out_valid}, {31'd0, v});
        if (v) begin
            check({tag, " byte"},  {24'd0, out_byte}, {24'd0, b});
            check({tag, " first"}, {31'd0, out_first}, {31'd0, f});
        end
        check({tag, " overflow"},  {31'd0, overflow},  {31'd0, ov});
        check({tag, " underflow"}, {31'd0, underflow}, {31'd0, un});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3'b111, 1'b0, 8'h00, 2'b00);
        step(3'b111, 1'b0, 8'h00, 2'b00);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        expect_out("R1 reset", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            step(v[25:23], v[22], v[21:14], v[13:12]);
            expect_out(TAGS[i], v[11], v[10], v[9:2], v[1], v[0]);
        end

        // R1: reset clears sticky flags and queue
        do_reset();
        expect_out("R1 flags cleared", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        step(3'b111, 1'b0, 8'h00, 2'b01);
        expect_out("R1 queue empty after reset", 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        do_reset();

        // R8: fill to capacity
        for (int k = 0; k < 6; k++) begin
            step(3'b100, 1'b1, 8'h10 + 8'(k), 2'b00);
        end
        expect_out("R8 full no overflow", 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);

        // R11: take and capture together while full
        step(3'b100, 1'b1, 8'h20, 2'b01);
        expect_out("R11 swap while full", 1'b1, 1'b1, 8'h10, 1'b0, 1'b0);

        // R8: one more capture overflows and is dropped
        step(3'b100, 1'b1, 8'h21, 2'b00);
        expect_out("R8 overflow set", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        step(3'b111, 1'b0, 8'h00, 2'b00);
        expect_out("R8 overflow sticky", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);

        // R7: drain in order, dropped byte absent
        step(3'b111, 1'b0, 8'h00, 2'b11);
        expect_out("R7 order 1", 1'b1, 1'b0, 8'h11, 1'b1, 1'b0);
        step(3'b111, 1'b0, 8'h00, 2'b11);
        expect_out("R7 order 2", 1'b1, 1'b0, 8'h12, 1'b1, 1'b0);
        step(3'b111, 1'b0, 8'h00, 2'b01);
        expect_out("R7 order 3", 1'b1, 1'b1, 8'h13, 1'b1, 1'b0);
        step(3'b111, 1'b0, 8'h00, 2'b11);
        expect_out("R7 order 4", 1'b1, 1'b0, 8'h14, 1'b1, 1'b0);
        step(3'b111, 1'b0, 8'h00, 2'b11);
        expect_out("R7 order 5", 1'b1, 1'b0, 8'h15, 1'b1, 1'b0);
        step(3'b111, 1'b0, 8'h00, 2'b11);
        expect_out("R11 swapped byte kept", 1'b1, 1'b0, 8'h20, 1'b1, 1'b0);
        step(3'b111, 1'b0, 8'h00, 2'b11);
        expect_out("R9 drained queue", 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        step(3'b111, 1'b0, 8'h00, 2'b00);
        expect_out("R9 underflow sticky", 1'b0, 1'b0, 8'h00, 1'b1, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule